// File: doc/BRIEF.md
# Four-Mode Serial Port with Address Filtering

This block is a byte-oriented serial port run through a small register bus. A baud divider produces a sample tick. Three asynchronous framings run at eight ticks per bit: 8 data bits, 9 data bits, and 9 data bits with address filtering. A synchronous shift mode runs at two ticks per bit. In that mode the `txd` pin carries the shift clock and the `rxd` pin pair carries the data in either direction. Data always goes least-significant bit first.

Software writes a byte to the data register to send it. The port keeps one byte in a holding slot. A byte written while a frame is on the line waits there until that frame's stop bit has ended. Received bytes land in a one-byte buffer that is read back at the same address. Two completion flags are shown in the status register and on the `tx_irq` and `rx_irq` pins. Reading the status register clears both flags.

In the address-filtering mode, a frame whose ninth bit is 0 is discarded. It leaves the buffer and the flags untouched. This lets a slave sleep through traffic meant for other nodes. When parity is enabled, the ninth status bit reports a parity error instead of the raw ninth bit.

Top module: `serial_port`

## Requirements
- R1: Mode 0 transmit. A data write sends 8 bits on `rxd_out`, LSB first, with `rxd_oe` high for the whole transfer. Each bit holds `txd` low for the first half and high for the second half. `txd` idles high. `tx_irq` is set once the last bit's clock has risen.
- R2: Mode 0 receive. A control write with bit 5 set shifts in 8 bits from `rxd_in`, LSB first, each sampled at the rising edge of `txd`. The byte then appears in the data register (address 0) and `rx_irq` is set.
- R3: Asynchronous transmit frame. The frame is a start bit (0), then the data LSB first, then a stop bit (1). Each bit lasts 8 ticks, and a tick comes every (divider+1) clocks; the divider is written at address 3. Mode 1 sends 8 data bits. Modes 2 and 3 send 9 data bits, with the ninth bit last.
- R4: The transmitted ninth bit is control bit 4. When control bit 2 (parity enable) is set, it is instead the even-parity bit of the 8 data bits.
- R5: The transmit-done flag (status bit 0) is set during the last data bit, before the stop bit starts.
- R6: A byte written while a frame is in progress is held. Its start bit begins at the first tick after the running frame's stop bit ends.
- R7: Asynchronous receive needs control bit 3 set. Each bit is decided by a majority of three samples near its centre, so a glitch shorter than one tick does not corrupt it. When the frame is done, the byte is in the data register, status bit 1 is set, and status bit 2 holds the ninth bit.
- R8: In mode 2, a frame whose ninth bit is 0 leaves the data register and status bit 1 unchanged. A frame whose ninth bit is 1 is received as in R7.
- R9: With parity enabled in modes 2 and 3, status bit 2 is set when the 9 received bits hold an odd number of ones, and clear otherwise.
- R10: A falling edge on `rxd_in` that reads high at the start-bit centre is rejected. No flag is set, and the next valid frame is received correctly.
- R11: A status read (address 2) returns the flags as they were before the read. It clears status bits 0 and 1 on the following cycle. Read data is registered and appears one cycle after `bus_rd`.
- R12: After reset, all flags are 0, `txd` is high and `rxd_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | 0 data, 1 control, 2 status, 3 baud divider |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| txd | output | 1 | Async serial out; shift clock in mode 0 |
| rxd_in | input | 1 | Async serial in; shift data in for mode 0 |
| rxd_out | output | 1 | Shift data out for mode 0 |
| rxd_oe | output | 1 | Drive enable for `rxd_out` |
| tx_irq | output | 1 | Transmit-done flag |
| rx_irq | output | 1 | Receive-done flag |

## Verification
The assertions assume that the mode and parity settings are not changed while a frame is in flight, and that the divider is stable during a transfer. The bench writes the control and divider registers only while the line is idle and both flags are cleared. Serial input is driven with whole bit periods of 32 clocks, matching a divider of 3. Glitches are kept shorter than one tick, so the majority vote must absorb them. Noise pulses are kept shorter than half a bit, so the start check must reject them.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT = 2'd0,
    MODE_UART8 = 2'd1,
    MODE_ADDR9 = 2'd2,
    MODE_UART9 = 2'd3
  } sp_mode_e;

  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_BAUD = 2'd3;

  localparam int CTRL_PAR  = 2;
  localparam int CTRL_REN  = 3;
  localparam int CTRL_TB8  = 4;
  localparam int CTRL_SHIN = 5;
endpackage

// File: rtl/sp_baud.sv
module sp_baud #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == '0);
      cnt  <= (cnt == '0) ? reload : cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sp_tx.sv
module sp_tx
  import sp_pkg::*;
#(
  parameter int OS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  sp_mode_e   mode,
  input  logic       par_en,
  input  logic       tb8,
  input  logic       load,
  input  logic [7:0] load_data,
  input  logic       shin_req,
  input  logic       rxd_s,
  output logic       txd,
  output logic       rxd_out,
  output logic       rxd_oe,
  output logic       done_ev,
  output logic       shin_ev,
  output logic [7:0] shin_data
);
  localparam int PH_W = $clog2(OS);
  localparam int FR_W = 11;

  logic             hold_v, hold_rx, busy, dir_in, sync_m, nine, ninth_slot;
  logic [7:0]       hold_d, rsh;
  logic [FR_W-1:0]  sh;
  logic [3:0]       bitn, last_data, last_bit;
  logic [PH_W-1:0]  ph, ph_last, ph_mid;

  always_comb begin
    sync_m  = (mode == MODE_SHIFT);
    ph_last = sync_m ? PH_W'(1) : PH_W'(OS - 1);
    ph_mid  = sync_m ? '0 : PH_W'(OS / 2 - 1);
    case (mode)
      MODE_SHIFT: last_data = 4'd7;
      MODE_UART8: last_data = 4'd8;
      default:    last_data = 4'd9;
    endcase
    last_bit   = sync_m ? 4'd7 : last_data + 4'd1;
    nine       = par_en ? ^hold_d : tb8;
    ninth_slot = (mode == MODE_UART8) ? 1'b1 : nine;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0; hold_rx <= 1'b0; busy <= 1'b0; dir_in <= 1'b0;
      hold_d <= '0;   rsh <= '0;       sh <= '1;      bitn <= '0;
      ph <= '0;       done_ev <= 1'b0; shin_ev <= 1'b0;
    end else begin
      done_ev <= 1'b0;
      shin_ev <= 1'b0;
      if (tick) begin
        if (!busy) begin
          if (hold_v) begin
            busy <= 1'b1; dir_in <= 1'b0; hold_v <= 1'b0; ph <= '0; bitn <= '0;
            sh <= sync_m ? {3'b111, hold_d} : {1'b1, ninth_slot, hold_d, 1'b0};
          end else if (hold_rx && sync_m) begin
            busy <= 1'b1; dir_in <= 1'b1; hold_rx <= 1'b0; ph <= '0; bitn <= '0;
          end
        end else begin
          if (ph == ph_mid && dir_in) rsh <= {rxd_s, rsh[7:1]};
          if (ph == ph_mid && bitn == last_data) begin
            if (dir_in) shin_ev <= 1'b1;
            else        done_ev <= 1'b1;
          end
          if (ph == ph_last) begin
            ph <= '0;
            sh <= {1'b1, sh[FR_W-1:1]};
            if (bitn == last_bit) busy <= 1'b0;
            else                  bitn <= bitn + 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
        end
      end
      if (load) begin
        hold_v <= 1'b1;
        hold_d <= load_data;
      end
      if (shin_req) hold_rx <= 1'b1;
    end
  end

  assign txd       = busy ? (sync_m ? ph[0] : sh[0]) : 1'b1;
  assign rxd_out   = sh[0];
  assign rxd_oe    = busy & sync_m & ~dir_in;
  assign shin_data = rsh;
endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import sp_pkg::*;
#(
  parameter int OS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  sp_mode_e   mode,
  input  logic       par_en,
  input  logic       rxd_s,
  output logic       done_ev,
  output logic [7:0] data,
  output logic       flag
);
  localparam int PH_W = $clog2(OS);
  localparam logic [PH_W-1:0] S0 = PH_W'(OS / 2 - 1);
  localparam logic [PH_W-1:0] S1 = PH_W'(OS / 2);
  localparam logic [PH_W-1:0] S2 = PH_W'(OS / 2 + 1);
  localparam logic [PH_W-1:0] PL = PH_W'(OS - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_RUN, RX_WAIT} rx_st_e;

  rx_st_e          st;
  logic [PH_W-1:0] ph;
  logic [3:0]      bitn, last_data;
  logic [1:0]      samp;
  logic [8:0]      rsh, nxt;
  logic            vote, wide, accept;

  always_comb begin
    vote      = (samp[0] & samp[1]) | (samp[0] & rxd_s) | (samp[1] & rxd_s);
    nxt       = {vote, rsh[8:1]};
    wide      = (mode != MODE_UART8);
    last_data = wide ? 4'd9 : 4'd8;
    accept    = (mode != MODE_ADDR9) | nxt[8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= RX_IDLE; ph <= '0; bitn <= '0; samp <= '0; rsh <= '0;
      done_ev <= 1'b0; data <= '0; flag <= 1'b0;
    end else begin
      done_ev <= 1'b0;
      if (!en) begin
        st <= RX_IDLE;
      end else if (tick) begin
        case (st)
          RX_IDLE: if (!rxd_s) begin
            st <= RX_RUN; ph <= '0; bitn <= '0;
          end
          RX_RUN: begin
            ph <= (ph == PL) ? '0 : ph + 1'b1;
            if (ph == PL) bitn <= bitn + 1'b1;
            if (ph == S0) samp[0] <= rxd_s;
            if (ph == S1) samp[1] <= rxd_s;
            if (ph == S2) begin
              if (bitn == '0) begin
                if (vote) st <= RX_IDLE;
              end else begin
                rsh <= nxt;
                if (bitn == last_data) begin
                  st <= RX_WAIT;
                  if (accept) begin
                    done_ev <= 1'b1;
                    data    <= wide ? nxt[7:0] : nxt[8:1];
                    flag    <= !wide ? 1'b0 : (par_en ? ^nxt : nxt[8]);
                  end
                end
              end
            end
          end
          RX_WAIT: if (rxd_s) st <= RX_IDLE;
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_port.sv
module serial_port
  import sp_pkg::*;
#(
  parameter int DIV_W = 15,
  parameter int OS    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        txd,
  input  logic        rxd_in,
  output logic        rxd_out,
  output logic        rxd_oe,
  output logic        tx_irq,
  output logic        rx_irq
);
  sp_mode_e         cfg_mode;
  logic             cfg_par, cfg_ren, cfg_tb8;
  logic [DIV_W-1:0] baud_div;
  logic [7:0]       rx_buf, arx_data, srx_data;
  logic             stat_tx, stat_rx, stat_nine;
  logic             rxd_meta, rxd_s, tick;
  logic             tx_ev, arx_ev, arx_flag, srx_ev;
  logic             wr_data, wr_ctrl, wr_baud, rd_stat;

  assign wr_data = bus_wr && (bus_addr == REG_DATA);
  assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
  assign wr_baud = bus_wr && (bus_addr == REG_BAUD);
  assign rd_stat = bus_rd && (bus_addr == REG_STAT);

  sp_baud #(.DIV_W(DIV_W)) i_baud (
    .clk(clk), .rst_n(rst_n), .reload(baud_div), .tick(tick)
  );

  sp_tx #(.OS(OS)) i_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(cfg_mode), .par_en(cfg_par),
    .tb8(cfg_tb8), .load(wr_data), .load_data(bus_wdata[7:0]),
    .shin_req(wr_ctrl && bus_wdata[CTRL_SHIN]), .rxd_s(rxd_s),
    .txd(txd), .rxd_out(rxd_out), .rxd_oe(rxd_oe),
    .done_ev(tx_ev), .shin_ev(srx_ev), .shin_data(srx_data)
  );

  sp_rx #(.OS(OS)) i_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .en(cfg_ren && (cfg_mode != MODE_SHIFT)), .mode(cfg_mode), .par_en(cfg_par),
    .rxd_s(rxd_s), .done_ev(arx_ev), .data(arx_data), .flag(arx_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_mode <= MODE_SHIFT; cfg_par <= 1'b0; cfg_ren <= 1'b0; cfg_tb8 <= 1'b0;
      baud_div <= '0; rx_buf <= '0; stat_tx <= 1'b0; stat_rx <= 1'b0;
      stat_nine <= 1'b0; rxd_meta <= 1'b1; rxd_s <= 1'b1; bus_rdata <= '0;
    end else begin
      rxd_meta <= rxd_in;
      rxd_s    <= rxd_meta;
      if (wr_ctrl) begin
        cfg_mode <= sp_mode_e'(bus_wdata[1:0]);
        cfg_par  <= bus_wdata[CTRL_PAR];
        cfg_ren  <= bus_wdata[CTRL_REN];
        cfg_tb8  <= bus_wdata[CTRL_TB8];
      end
      if (wr_baud) baud_div <= bus_wdata[DIV_W-1:0];
      if (rd_stat) begin
        stat_tx <= 1'b0;
        stat_rx <= 1'b0;
      end
      if (tx_ev) stat_tx <= 1'b1;
      if (arx_ev) begin
        stat_rx   <= 1'b1;
        rx_buf    <= arx_data;
        stat_nine <= arx_flag;
      end
      if (srx_ev) begin
        stat_rx <= 1'b1;
        rx_buf  <= srx_data;
      end
      if (bus_rd) begin
        case (bus_addr)
          REG_DATA: bus_rdata <= {8'h00, rx_buf};
          REG_CTRL: bus_rdata <= {11'd0, cfg_tb8, cfg_ren, cfg_par, cfg_mode};
          REG_STAT: bus_rdata <= {13'd0, stat_nine, stat_rx, stat_tx};
          default:  bus_rdata <= 16'(baud_div);
        endcase
      end
    end
  end

  assign tx_irq = stat_tx;
  assign rx_irq = stat_rx;
endmodule

// File: rtl/sp_chk.sv
module sp_chk
  import sp_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_rd,
  input logic [1:0]  bus_addr,
  input logic [15:0] bus_rdata,
  input logic        rxd_oe,
  input logic        tx_irq,
  input logic        rx_irq,
  input logic [1:0]  mode,
  input logic        par,
  input logic        nine
);
  // R1
  oe_shift_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_oe |-> (mode == 2'd0));

  // R11
  tx_clear_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_irq) |-> $past(bus_rd && bus_addr == REG_STAT));

  // R11
  rx_clear_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_irq) |-> $past(bus_rd && bus_addr == REG_STAT));

  // R11
  stat_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == REG_STAT) |=> (bus_rdata[1:0] == $past({rx_irq, tx_irq})));

  // R8
  addr_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_irq) && mode == 2'd2 && !par) |-> nine);
endmodule

bind serial_port sp_chk i_sp_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .rxd_oe(rxd_oe), .tx_irq(tx_irq), .rx_irq(rx_irq),
  .mode(cfg_mode), .par(cfg_par), .nine(stat_nine)
);

// File: tb/test_serial_port.sv
module test_serial_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        txd, rxd_out, rxd_oe, tx_irq, rx_irq;
  logic        rxd_in = 1'b1;
  int          n_chk = 0, n_fail = 0;

  localparam int BIT = 32;

  always #2.5 clk = ~clk;

  serial_port i_serial_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txd(txd), .rxd_in(rxd_in),
    .rxd_out(rxd_out), .rxd_oe(rxd_oe), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic clr();
    logic [15:0] d;
    rd(2'd2, d);
  endtask

  task automatic wait_txd(input logic v);
    for (int i = 0; i < 4000 && txd !== v; i++) @(negedge clk);
  endtask

  task automatic cap_frame(input int nb, output logic [10:0] lv, output logic [10:0] irq);
    lv = '1; irq = '0;
    wait_txd(1'b0);
    repeat (BIT / 2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      lv[i] = txd;
      repeat (8) @(negedge clk);
      irq[i] = tx_irq;
      repeat (BIT - 8) @(negedge clk);
    end
  endtask

  task automatic send(input logic [8:0] v, input int nd, input int gbit);
    @(negedge clk);
    rxd_in = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < nd; i++) begin
      rxd_in = v[i];
      if (i == gbit) begin
        repeat (14) @(negedge clk); rxd_in = ~v[i];
        repeat (3) @(negedge clk);  rxd_in = v[i];
        repeat (BIT - 17) @(negedge clk);
      end else begin
        repeat (BIT) @(negedge clk);
      end
    end
    rxd_in = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd2, d);
    chk("R12 status", d, 0);
    chk("R12 txd/oe/irq", {txd, rxd_oe, tx_irq, rx_irq}, 4'b1000);
  endtask

  task automatic t_async9_tx();
    logic [10:0] lv, irq;
    logic [15:0] d;
    wr(2'd3, 16'd3);
    wr(2'd1, 16'h0003);
    clr();
    wr(2'd0, 16'h00A5);
    cap_frame(11, lv, irq);
    chk("R3 mode3 frame", lv, {1'b1, 1'b0, 8'hA5, 1'b0});
    chk("R5 not set before last data bit", irq[8], 0);
    chk("R5 set inside last data bit", {irq[9], lv[9]}, 2'b10);
    rd(2'd2, d);
    chk("R11 read returns flag", d[0], 1);
    rd(2'd2, d);
    chk("R11 flag cleared by read", d[0], 0);
  endtask

  task automatic t_held();
    logic [10:0] lv, irq;
    logic [7:0] b;
    wr(2'd1, 16'h0001);
    clr();
    wr(2'd0, 16'h003C);
    fork
      cap_frame(10, lv, irq);
      begin repeat (60) @(negedge clk); wr(2'd0, 16'h00E1); end
    join
    chk("R3 mode1 frame", lv[9:0], {1'b1, 8'h3C, 1'b0});
    chk("R6 next start right after stop", txd, 0);
    for (int k = 0; k < 8; k++) begin
      repeat (BIT) @(negedge clk);
      b[k] = txd;
    end
    chk("R6 held byte sent", b, 8'hE1);
    repeat (BIT) @(negedge clk);
    chk("R6 held byte stop", txd, 1);
    repeat (BIT) @(negedge clk);
  endtask

  task automatic t_par_tx();
    logic [10:0] lv, irq;
    wr(2'd1, 16'h0017);
    wr(2'd0, 16'h0007);
    cap_frame(11, lv, irq);
    chk("R4 even parity ninth bit", lv[10:9], 2'b11);
    wr(2'd1, 16'h0003);
    wr(2'd0, 16'h0003);
    cap_frame(11, lv, irq);
    chk("R4 tb8 ninth bit", lv[10:9], 2'b10);
    clr();
  endtask

  task automatic t_async_rx();
    logic [15:0] d;
    wr(2'd1, 16'h0008 | 16'h0003);
    clr();
    send(9'h15A, 9, 3);
    chk("R7 rx flag", rx_irq, 1);
    rd(2'd0, d);
    chk("R7 data with glitch", d, 16'h005A);
    rd(2'd2, d);
    chk("R7 ninth bit status", d[2:1], 2'b11);
    @(negedge clk); rxd_in = 1'b0;
    repeat (8) @(negedge clk); rxd_in = 1'b1;
    repeat (200) @(negedge clk);
    chk("R10 noise start ignored", rx_irq, 0);
    send(9'h0C3, 9, -1);
    rd(2'd0, d);
    chk("R10 next frame received", {rx_irq, d[7:0]}, 9'h1C3);
    clr();
  endtask

  task automatic t_filter();
    logic [15:0] d;
    wr(2'd1, 16'h000A);
    clr();
    send(9'h011, 9, -1);
    rd(2'd0, d);
    chk("R8 ninth=0 dropped", {rx_irq, d[7:0]}, 9'h0C3);
    send(9'h122, 9, -1);
    rd(2'd0, d);
    chk("R8 ninth=1 accepted", {rx_irq, d[7:0]}, 9'h122);
    rd(2'd2, d);
    chk("R8 ninth status", d[2], 1);
  endtask

  task automatic t_par_rx();
    logic [15:0] d;
    wr(2'd1, 16'h000F);
    clr();
    send(9'h007, 9, -1);
    rd(2'd2, d);
    chk("R9 parity error flagged", d[2:1], 2'b11);
    send(9'h107, 9, -1);
    rd(2'd2, d);
    chk("R9 good parity", d[2:1], 2'b01);
  endtask

  task automatic t_shift_tx();
    logic [7:0] b;
    logic oe_ok;
    wr(2'd1, 16'h0000);
    clr();
    oe_ok = 1'b1;
    wr(2'd0, 16'h0096);
    wait_txd(1'b0);
    for (int i = 0; i < 8; i++) begin
      wait_txd(1'b1);
      b[i] = rxd_out;
      oe_ok = oe_ok & rxd_oe;
      if (i < 7) wait_txd(1'b0);
    end
    repeat (12) @(negedge clk);
    chk("R1 shifted byte", b, 8'h96);
    chk("R1 oe during transfer", oe_ok, 1);
    chk("R1 done and idle", {tx_irq, txd, rxd_oe}, 3'b110);
    clr();
  endtask

  task automatic t_shift_rx();
    logic [15:0] d;
    logic [7:0] v;
    v = 8'h5B;
    wr(2'd1, 16'h0020);
    wait_txd(1'b0);
    for (int i = 0; i < 8; i++) begin
      rxd_in = v[i];
      wait_txd(1'b1);
      if (i < 7) wait_txd(1'b0);
    end
    repeat (12) @(negedge clk);
    rxd_in = 1'b1;
    chk("R2 rx flag", rx_irq, 1);
    rd(2'd0, d);
    chk("R2 shifted-in byte", d, 16'h005B);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_async9_tx();
    t_held();
    t_par_tx();
    t_async_rx();
    t_filter();
    t_par_rx();
    t_shift_tx();
    t_shift_rx();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule